// File: doc/BRIEF.md
# Fractional 1/32-Step Clock Rate Scaler

This block lowers the effective rate of its input clock by a factor mult/32, with mult anywhere from 1 to 32. No new clock is generated from scratch; instead the block lets through exactly mult of every 32 input cycles and suppresses the others. The surviving cycles are spread as evenly as possible across each 32-cycle frame, so downstream logic sees a steady, low-jitter rate rather than a burst.

The rate is set through a 5-bit field that sits inside a wider frequency control register. The field stores 32 minus mult, so its reset value of zero means full rate. The register can be written whole, or only its rate field can be updated. A field-only update leaves every other bit untouched. A new rate takes effect only at the start of the next 32-cycle frame, so a frame never mixes two rates. The main output is a one-cycle clock enable. A glitch-free gated clock derived from that enable is available as a build option. A pulse counter reports how many cycles passed in the last complete frame.

Top module: `frac_rate_scaler`

## Requirements
- R1: While the synchronous reset is high, `pulse_en` is 0 and `frame_count` is 0. After reset, `rd_data` is the reset value, which is 0 by default. The frame that starts when reset is released runs at the rate given by the reset value of the field.
- R2: With `wr_en` high, all 32 bits of `wr_data` are stored in the control register. The stored value appears on `rd_data` in the following cycle.
- R3: With `fld_wr` high and `wr_en` low, bits 12:8 of the control register take `fld_data`. All other register bits keep their previous value.
- R4: When `wr_en` and `fld_wr` are both high in the same cycle, the register takes `wr_data` with bits 12:8 replaced by `fld_data`.
- R5: If field code c is active for a frame, `pulse_en` is high in exactly 32-c of that frame's 32 cycles, which means mult = 32-c.
- R6: Code 0 gives a pulse on every cycle of the frame. Code 31 gives exactly one pulse per frame.
- R7: While the same mult stays active, the spacing between consecutive pulses is always floor(32/mult) or ceil(32/mult) cycles, including across frame boundaries.
- R8: A write in any cycle of a frame, including its last cycle, leaves that frame's rate unchanged. The new rate applies from the first cycle of the next frame.
- R9: `frame_count` changes only at the end of a frame. It then holds the number of pulses in the frame that just ended, in the range 0 to 32.
- R10: When the `GATED_CLK` build option is 1, `gclk` has exactly one rising edge for each cycle in which `pulse_en` was high. That edge comes at the clock edge that ends the pulsed cycle, and `gclk` has no other rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (parent) clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write the whole control register |
| wr_data | input | 32 | Data for a whole-register write |
| fld_wr | input | 1 | Update only the rate field (bits 12:8) |
| fld_data | input | 5 | New rate field value, equal to 32 minus mult |
| rd_data | output | 32 | Current control register contents |
| pulse_en | output | 1 | One-cycle clock enable, high on the cycles that pass |
| gclk | output | 1 | Glitch-free gated clock, or 0 when the option is off |
| frame_count | output | 6 | Number of pulses in the last complete frame |

## Verification
Two events can land in the same cycle. The first is a register write in the last cycle of a frame, the same cycle in which the frame boundary latches the active rate. The bench deliberately places writes at position 31, both a field-only write and a combined whole-register plus field write. It then judges the result by the number of pulses in the next frame, which must already reflect the new code. The second coincidence is a whole-register write and a field update arriving together. The bench checks the merged value on `rd_data` against its own register model. A sweep of every code, with the write placed at a different position within each frame, confirms pulse counts, spacing and frame-boundary timing arithmetically.

// File: rtl/frs_pkg.sv
package frs_pkg;

    localparam int FRS_FLD_W  = 5;
    localparam int FRS_FRAME  = 1 << FRS_FLD_W;
    localparam int FRS_MULT_W = FRS_FLD_W + 1;

    typedef logic [FRS_FLD_W-1:0]  code_t;
    typedef logic [FRS_MULT_W-1:0] mult_t;

    // accumulator, frame position, and the code active for this frame
    typedef struct packed {
        code_t acc;
        code_t pos;
        code_t act;
    } phase_t;

    typedef struct packed {
        logic  carry;
        code_t rem;
    } step_t;

    function automatic mult_t code_to_mult(code_t c);
        return mult_t'(FRS_FRAME) - mult_t'(c);
    endfunction

    function automatic step_t acc_step(code_t acc, mult_t m);
        mult_t s;
        s = mult_t'(acc) + m;
        return step_t'(s);
    endfunction

endpackage

// File: rtl/frs_ctrl_reg.sv
module frs_ctrl_reg
    import frs_pkg::*;
#(
    parameter int               REG_W   = 32,
    parameter int               FLD_LSB = 8,
    parameter logic [REG_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             fld_wr,
    input  code_t            fld_data,
    output logic [REG_W-1:0] reg_q,
    output code_t            fld_next
);
    localparam int FLD_MSB = FLD_LSB + FRS_FLD_W - 1;
    localparam logic [REG_W-1:0] FLD_MASK =
        {{(REG_W-FRS_FLD_W){1'b0}}, {FRS_FLD_W{1'b1}}} << FLD_LSB;

    logic [REG_W-1:0] reg_d;

    // whole write first, field update overrides its field (R4)
    always_comb begin
        reg_d = wr_en ? wr_data : reg_q;
        if (fld_wr)
            reg_d[FLD_MSB:FLD_LSB] = fld_data;
    end

    assign fld_next = reg_d[FLD_MSB:FLD_LSB];

    always_ff @(posedge clk) begin
        if (rst) reg_q <= RST_VAL;
        else     reg_q <= reg_d;
    end

    // R3: field-only update keeps every bit outside the field
    assert_fld_keeps_rest_R3: assert property (@(posedge clk) disable iff (rst)
        (fld_wr && !wr_en) |=> ((reg_q & ~FLD_MASK) == $past(reg_q & ~FLD_MASK)));

endmodule

// File: rtl/frs_phase_gen.sv
module frs_phase_gen
    import frs_pkg::*;
#(
    parameter code_t RST_CODE = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  code_t next_code,
    output logic  pulse,
    output logic  frame_last
);
    localparam code_t LAST_POS = code_t'(FRS_FRAME - 1);

    phase_t st;
    step_t  stp;

    always_comb begin
        stp        = acc_step(st.acc, code_to_mult(st.act));
        pulse      = stp.carry & ~rst;
        frame_last = (st.pos == LAST_POS) & ~rst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{acc: '0, pos: '0, act: RST_CODE};
        end else begin
            st.acc <= stp.rem;
            st.pos <= st.pos + 1'b1;
            if (frame_last)
                st.act <= next_code;
        end
    end

    // R8: the active code changes only across a frame boundary
    assert_act_frame_only_R8: assert property (@(posedge clk) disable iff (rst)
        !frame_last |=> $stable(st.act));

    // R6: code 0 passes every cycle
    assert_full_rate_R6: assert property (@(posedge clk) disable iff (rst)
        (st.act == '0) |-> pulse);

endmodule

// File: rtl/frs_frame_meter.sv
module frs_frame_meter
    import frs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pulse,
    input  logic  frame_last,
    output mult_t frame_count
);
    mult_t run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt     <= '0;
            frame_count <= '0;
        end else if (frame_last) begin
            frame_count <= run_cnt + mult_t'(pulse);
            run_cnt     <= '0;
        end else begin
            run_cnt <= run_cnt + mult_t'(pulse);
        end
    end

    // R5: a frame never reports more pulses than it has cycles
    assert_count_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        frame_count <= mult_t'(FRS_FRAME));

    // R9: report holds between frame ends
    assert_count_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !frame_last |=> $stable(frame_count));

endmodule

// File: rtl/frs_clk_gate.sv
module frs_clk_gate #(
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    generate
        if (ENABLE) begin : g_gate
            logic en_l;
            // transparent while clk is low: enable is frozen over the high phase
            always_latch begin
                if (!clk) en_l = en;
            end
            assign gclk = clk & en_l;
        end else begin : g_off
            logic unused_in;
            assign unused_in = clk ^ en;
            assign gclk      = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/frac_rate_scaler.sv
module frac_rate_scaler
    import frs_pkg::*;
#(
    parameter int               REG_W     = 32,
    parameter int               FLD_LSB   = 8,
    parameter logic [REG_W-1:0] RST_VAL   = '0,
    parameter bit               GATED_CLK = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wr_data,
    input  logic                  fld_wr,
    input  logic [FRS_FLD_W-1:0]  fld_data,
    output logic [REG_W-1:0]      rd_data,
    output logic                  pulse_en,
    output logic                  gclk,
    output logic [FRS_MULT_W-1:0] frame_count
);
    localparam code_t RST_CODE = RST_VAL[FLD_LSB +: FRS_FLD_W];

    code_t fld_next;
    logic  frame_last;

    frs_ctrl_reg #(
        .REG_W   (REG_W),
        .FLD_LSB (FLD_LSB),
        .RST_VAL (RST_VAL)
    ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .fld_wr   (fld_wr),
        .fld_data (fld_data),
        .reg_q    (rd_data),
        .fld_next (fld_next)
    );

    frs_phase_gen #(
        .RST_CODE (RST_CODE)
    ) u_phase (
        .clk        (clk),
        .rst        (rst),
        .next_code  (fld_next),
        .pulse      (pulse_en),
        .frame_last (frame_last)
    );

    frs_frame_meter u_meter (
        .clk         (clk),
        .rst         (rst),
        .pulse       (pulse_en),
        .frame_last  (frame_last),
        .frame_count (frame_count)
    );

    frs_clk_gate #(
        .ENABLE (GATED_CLK)
    ) u_gate (
        .clk  (clk),
        .en   (pulse_en),
        .gclk (gclk)
    );

    // R1: no enable while reset is held
    assert_quiet_in_reset_R1: assert property (@(posedge clk)
        rst |-> !pulse_en);

endmodule

// File: tb/tb_frac_rate_scaler.sv
module tb_frac_rate_scaler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        fld_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  fld_data = '0;
    logic [31:0] rd_data;
    logic        pulse_en;
    logic        gclk;
    logic [5:0]  frame_count;

    always #10 clk = ~clk;

    frac_rate_scaler dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .fld_wr      (fld_wr),
        .fld_data    (fld_data),
        .rd_data     (rd_data),
        .pulse_en    (pulse_en),
        .gclk        (gclk),
        .frame_count (frame_count)
    );

    int          checks = 0;
    int          failures = 0;
    int          t = 0;
    logic [31:0] ref_reg = '0;
    int          cur_mult = 32;
    int          closed_mult = 0;
    int          frame_pulses = 0;
    bit          frame_had_write = 0;
    int          last_pulse_t = -1;
    int          last_pulse_mult = 0;
    int          gclk_hits = 0;
    int          gclk_seen = 0;
    int          gmis = 0;
    logic        prev_pulse = 1'b0;
    string       wtag = "R2";

    always @(posedge gclk) gclk_hits++;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(bit w, logic [31:0] wd, bit f, logic [4:0] fd);
        int pos;
        int d;
        int gap;
        int lo;
        int hi;
        string tg;
        @(negedge clk);
        pos = t % 32;
        d = gclk_hits - gclk_seen;
        gclk_seen = gclk_hits;
        if (d != int'(prev_pulse)) gmis++;
        if (pos == 0 && t > 0) begin
            if (frame_had_write)                    tg = "R8";
            else if (cur_mult == 32 || cur_mult == 1) tg = "R6";
            else                                    tg = "R5";
            chk(frame_pulses == cur_mult, tg, "pulses in frame", frame_pulses, cur_mult);
            chk(frame_count == cur_mult, "R9", "frame_count at boundary", frame_count, cur_mult);
            closed_mult = cur_mult;
            cur_mult = 32 - int'(ref_reg[12:8]);
            frame_pulses = 0;
            frame_had_write = 0;
        end
        if (pos == 16 && t >= 32)
            chk(frame_count == closed_mult, "R9", "frame_count holds mid-frame", frame_count, closed_mult);
        chk(rd_data == ref_reg, wtag, "rd_data", rd_data, ref_reg);
        if (pulse_en) begin
            frame_pulses++;
            if (last_pulse_t >= 0 && last_pulse_mult == cur_mult) begin
                gap = t - last_pulse_t;
                lo = 32 / cur_mult;
                hi = (32 + cur_mult - 1) / cur_mult;
                chk(gap >= lo && gap <= hi, "R7", "pulse spacing", gap, lo);
            end
            last_pulse_t = t;
            last_pulse_mult = cur_mult;
        end
        prev_pulse = pulse_en;
        wr_en = w;
        wr_data = wd;
        fld_wr = f;
        fld_data = fd;
        if (w) ref_reg = wd;
        if (f) ref_reg[12:8] = fd;
        if (w || f) frame_had_write = 1;
        if (w && f)  wtag = "R4";
        else if (f)  wtag = "R3";
        else         wtag = "R2";
        t++;
    endtask

    task automatic run_frame(int wpos, bit w, logic [31:0] wd, bit f, logic [4:0] fd);
        for (int p = 0; p < 32; p++) begin
            if (p == wpos) tick(w, wd, f, fd);
            else           tick(1'b0, '0, 1'b0, '0);
        end
    endtask

    initial begin : watchdog
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", t, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pulse_en == 1'b0, "R1", "pulse_en in reset", pulse_en, 0);
        chk(frame_count == 6'd0, "R1", "frame_count in reset", frame_count, 0);
        chk(rd_data == 32'd0, "R1", "rd_data after reset", rd_data, 0);
        @(posedge clk);
        #1 rst = 1'b0;

        run_frame(-1, 1'b0, '0, 1'b0, '0);                // full rate from reset
        run_frame(3, 1'b1, 32'hDEAD_BEEF, 1'b0, '0);       // whole write
        run_frame(10, 1'b0, '0, 1'b1, 5'd7);               // field only
        run_frame(31, 1'b1, 32'h1234_5678, 1'b1, 5'd20);   // both, on the boundary
        run_frame(31, 1'b0, '0, 1'b1, 5'd31);              // boundary write, one pulse
        run_frame(16, 1'b0, '0, 1'b1, 5'd0);               // mid-frame, frame keeps rate
        run_frame(-1, 1'b0, '0, 1'b0, '0);
        for (int c = 0; c < 32; c++) begin
            run_frame(c, 1'b0, '0, 1'b1, 5'(c));
            run_frame(-1, 1'b0, '0, 1'b0, '0);
        end
        run_frame(-1, 1'b0, '0, 1'b0, '0);
        tick(1'b0, '0, 1'b0, '0);

        chk(gmis == 0, "R10", "gated clock edge mismatches", gmis, 0);
        chk(gclk_hits > 0, "R10", "gated clock edges seen", gclk_hits, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule